// File: doc/BRIEF.md
# Local Interrupt Controller Base and Mode Register

This block holds the 64-bit control word that locates and enables a processor's local interrupt controller. The word carries an enable flag, an extended-mode flag, a bootstrap-processor flag and a page-aligned base address. Software writes the word as a whole. Each write is tested before it is accepted. The test covers the reserved bits and a table of legal moves between the three operating modes: off, legacy and extended. A write that fails the test leaves the register exactly as it was and raises a one-cycle fault.

From the stored word the block derives several outputs. It reports the operating mode and the page address at which the controller's registers are decoded. It drives a capability flag that is set whenever the controller is on. It also holds the controller's identifier. The identifier can be written in legacy mode, is locked in extended mode, and reads as all ones while the controller is off. When a write turns the controller off, the block sends a one-cycle pulse so that the neighbouring controller registers return to their reset values. The identifier is reloaded at the same time.

Top module: `ctl_base_mode`

## Requirements
- R1: After reset, enable (bit 11) is 1, extended (bit 10) is 0, the bootstrap flag (bit 8) equals `bsp_strap`, the base equals `DEFAULT_BASE`, the identifier equals `init_id`, and `fault` and `regs_reset` are low.
- R2: A base write with bit 10 set and bit 11 clear is rejected from any mode. It leaves `base_rdata` unchanged and raises `fault`.
- R3: Mode moves follow a fixed table. The mode code is 00 for off, 01 for legacy and 10 for extended. Off to legacy, legacy to extended, legacy to off and extended to off are accepted. Off to extended and extended to legacy are rejected with a fault.
- R4: A base write is rejected with a fault if it sets any of bits 7:0, bit 9, or any bit at or above `PA_WIDTH`.
- R5: An accepted base write moves `decode_base` to the written page address, taken from bits `PA_WIDTH-1`:12. The low 12 bits are zero. `base_rdata` then returns the written value.
- R6: `fault` is high for exactly the one cycle after each rejected write and is low otherwise. A rejected write changes no stored bit.
- R7: While the mode is off, `id_rdata` is all ones and `cap_present` is 0. In the other modes `cap_present` is 1.
- R8: In legacy mode an identifier write takes `id_wdata[31:24]`. `id_rdata` then shows the identifier in bits 31:24 and zeros below.
- R9: In extended mode an identifier write is rejected with a fault and leaves the identifier unchanged. `id_rdata` shows the identifier in its low bits.
- R10: An accepted write that takes the controller from legacy or extended to off pulses `regs_reset` for one cycle and reloads the identifier from `init_id`.
- R11: An identifier write while the mode is off is ignored and raises no fault. This is visible by reading the identifier back after returning to legacy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bsp_strap | input | 1 | Reset value of the bootstrap-processor flag |
| init_id | input | ID_W | Reset and reload value of the identifier |
| base_wr | input | 1 | Write strobe for the base/mode word |
| base_wdata | input | 64 | Value written to the base/mode word |
| id_wr | input | 1 | Write strobe for the identifier |
| id_wdata | input | 32 | Value written to the identifier register |
| base_rdata | output | 64 | Current base/mode word |
| mode | output | 2 | 00 off, 01 legacy, 10 extended |
| decode_base | output | PA_WIDTH | Active decode address, page aligned |
| cap_present | output | 1 | Capability flag, set while the controller is on |
| id_rdata | output | 32 | Identifier read value for the current mode |
| fault | output | 1 | One-cycle pulse after a rejected write |
| regs_reset | output | 1 | One-cycle pulse when the controller is turned off |

## Verification
The bench steps through every edge of the mode table from each starting mode. It includes the extended-only pattern from both off and legacy, so that a table with a missing or swapped entry shows up as a wrong fault or a wrong mode. Reserved-bit patterns are tried one bit class at a time: a low bit, bit 9, the first bit above the address width and the top bit. Each one uses an otherwise legal word, so the reserved-bit check is exercised apart from the mode table. Identifier writes are issued in all three modes, and back-to-back rejected writes are included. Together these separate a correct lock, reload and all-ones read from a fault that lasts too long.

// File: rtl/ctl_bm_pkg.sv
`timescale 1ns/1ps
package ctl_bm_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_LEGACY = 2'b01,
      MODE_EXT    = 2'b10
   } ctl_mode_e;

   localparam int unsigned BIT_BSP  = 8;
   localparam int unsigned BIT_HOLE = 9;
   localparam int unsigned BIT_EXT  = 10;
   localparam int unsigned BIT_EN   = 11;
   localparam int unsigned PAGE_LSB = 12;
   localparam int unsigned WORD_W   = 64;

   function automatic ctl_mode_e mode_of(input logic en, input logic ext);
      if (!en)      return MODE_OFF;
      else if (ext) return MODE_EXT;
      else          return MODE_LEGACY;
   endfunction

endpackage

// File: rtl/ctl_bm_check.sv
`timescale 1ns/1ps
module ctl_bm_check
   import ctl_bm_pkg::*;
#(
   parameter int unsigned PA_WIDTH = 40
) (
   input  ctl_mode_e         cur_mode,
   input  logic [WORD_W-1:0] wdata,
   output logic              reject,
   output logic              turns_off
);

   logic [WORD_W-1:0] resv_mask;

   genvar gi;
   generate
      for (gi = 0; gi < WORD_W; gi++) begin : g_mask
         if (gi < BIT_BSP || gi == BIT_HOLE || gi >= PA_WIDTH) begin : g_resv
            assign resv_mask[gi] = 1'b1;
         end else begin : g_free
            assign resv_mask[gi] = 1'b0;
         end
      end
   endgenerate

   logic new_en, new_ext;
   logic resv_hit, ext_only, off_to_ext, ext_to_leg;

   always_comb begin
      new_en     = wdata[BIT_EN];
      new_ext    = wdata[BIT_EXT];
      resv_hit   = |(wdata & resv_mask);
      ext_only   = new_ext && !new_en;
      off_to_ext = (cur_mode == MODE_OFF) && new_en && new_ext;
      ext_to_leg = (cur_mode == MODE_EXT) && new_en && !new_ext;
      reject     = resv_hit || ext_only || off_to_ext || ext_to_leg;
      turns_off  = !reject && !new_en && (cur_mode != MODE_OFF);
   end

endmodule

// File: rtl/ctl_bm_store.sv
`timescale 1ns/1ps
module ctl_bm_store
   import ctl_bm_pkg::*;
#(
   parameter int unsigned      PA_WIDTH     = 40,
   parameter logic [WORD_W-1:0] DEFAULT_BASE = 64'h0000_0000_FEE0_0000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bsp_strap,
   input  logic                       wr,
   input  logic                       reject,
   input  logic                       turns_off,
   input  logic                       new_en,
   input  logic                       new_ext,
   input  logic                       new_bsp,
   input  logic [PA_WIDTH-1:PAGE_LSB] new_page,
   output logic [WORD_W-1:0]          word,
   output ctl_mode_e                  mode,
   output logic [PA_WIDTH-1:0]        page_addr,
   output logic                       rej_q,
   output logic                       off_pulse_q
);

   localparam int unsigned HI_PAD = WORD_W - PA_WIDTH;

   logic                       en_q, ext_q, bsp_q;
   logic [PA_WIDTH-1:PAGE_LSB] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q        <= 1'b1;
         ext_q       <= 1'b0;
         bsp_q       <= bsp_strap;
         page_q      <= DEFAULT_BASE[PA_WIDTH-1:PAGE_LSB];
         rej_q       <= 1'b0;
         off_pulse_q <= 1'b0;
      end else begin
         rej_q       <= wr && reject;
         off_pulse_q <= wr && turns_off;
         if (wr && !reject) begin
            en_q   <= new_en;
            ext_q  <= new_ext;
            bsp_q  <= new_bsp;
            page_q <= new_page;
         end
      end
   end

   always_comb begin
      mode      = mode_of(en_q, ext_q);
      page_addr = {page_q, {PAGE_LSB{1'b0}}};
      word      = {{HI_PAD{1'b0}}, page_q, en_q, ext_q, 1'b0, bsp_q, {BIT_BSP{1'b0}}};
   end

   p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rej_q |-> ($stable(en_q) && $stable(ext_q) && $stable(bsp_q) && $stable(page_q)));

   p_no_off_to_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_EXT) |-> ($past(mode) != MODE_OFF));

   p_no_ext_to_leg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LEGACY) |-> ($past(mode) != MODE_EXT));

   p_off_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      off_pulse_q |-> ((mode == MODE_OFF) && ($past(mode) != MODE_OFF)));

endmodule

// File: rtl/ctl_bm_id.sv
`timescale 1ns/1ps
module ctl_bm_id
   import ctl_bm_pkg::*;
#(
   parameter int unsigned ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] init_id,
   input  ctl_mode_e       mode,
   input  logic            wr,
   input  logic [ID_W-1:0] wr_id,
   input  logic            reload,
   output logic [31:0]     rdata,
   output logic            rej_q
);

   localparam int unsigned PAD_W = 32 - ID_W;

   logic [ID_W-1:0] id_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q  <= init_id;
         rej_q <= 1'b0;
      end else begin
         rej_q <= wr && (mode == MODE_EXT);
         if (reload) begin
            id_q <= init_id;
         end else if (wr && (mode == MODE_LEGACY)) begin
            id_q <= wr_id;
         end
      end
   end

   always_comb begin
      unique case (mode)
         MODE_LEGACY: rdata = {id_q, {PAD_W{1'b0}}};
         MODE_EXT:    rdata = {{PAD_W{1'b0}}, id_q};
         default:     rdata = '1;
      endcase
   end

   p_ext_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode == MODE_EXT) && (mode == MODE_EXT)) |-> $stable(id_q));

   p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reload) |-> (id_q == $past(init_id)));

endmodule

// File: rtl/ctl_base_mode.sv
`timescale 1ns/1ps
module ctl_base_mode
   import ctl_bm_pkg::*;
#(
   parameter int unsigned       PA_WIDTH     = 40,
   parameter int unsigned       ID_W         = 8,
   parameter logic [WORD_W-1:0] DEFAULT_BASE = 64'h0000_0000_FEE0_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bsp_strap,
   input  logic [ID_W-1:0]     init_id,
   input  logic                base_wr,
   input  logic [63:0]         base_wdata,
   input  logic                id_wr,
   input  logic [31:0]         id_wdata,
   output logic [63:0]         base_rdata,
   output logic [1:0]          mode,
   output logic [PA_WIDTH-1:0] decode_base,
   output logic                cap_present,
   output logic [31:0]         id_rdata,
   output logic                fault,
   output logic                regs_reset
);

   localparam int unsigned ID_LO = 32 - ID_W;

   generate
      if (PA_WIDTH <= PAGE_LSB || PA_WIDTH > WORD_W - 1) begin : g_bad_pa
         $error("PA_WIDTH must lie between 13 and 63");
      end
      if (ID_W < 1 || ID_W > 16) begin : g_bad_id
         $error("ID_W must lie between 1 and 16");
      end
      if (DEFAULT_BASE[PAGE_LSB-1:0] != '0 || (DEFAULT_BASE >> PA_WIDTH) != '0) begin : g_bad_base
         $error("DEFAULT_BASE must be page aligned and inside PA_WIDTH");
      end
   endgenerate

   ctl_mode_e cur_mode;
   logic      reject, turns_off, reload;
   logic      base_rej_q, id_rej_q;

   ctl_bm_check #(.PA_WIDTH(PA_WIDTH)) u_check (
      .cur_mode  (cur_mode),
      .wdata     (base_wdata),
      .reject    (reject),
      .turns_off (turns_off)
   );

   ctl_bm_store #(.PA_WIDTH(PA_WIDTH), .DEFAULT_BASE(DEFAULT_BASE)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .bsp_strap   (bsp_strap),
      .wr          (base_wr),
      .reject      (reject),
      .turns_off   (turns_off),
      .new_en      (base_wdata[BIT_EN]),
      .new_ext     (base_wdata[BIT_EXT]),
      .new_bsp     (base_wdata[BIT_BSP]),
      .new_page    (base_wdata[PA_WIDTH-1:PAGE_LSB]),
      .word        (base_rdata),
      .mode        (cur_mode),
      .page_addr   (decode_base),
      .rej_q       (base_rej_q),
      .off_pulse_q (regs_reset)
   );

   assign reload = base_wr && turns_off;

   ctl_bm_id #(.ID_W(ID_W)) u_id (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_id (init_id),
      .mode    (cur_mode),
      .wr      (id_wr),
      .wr_id   (id_wdata[31:ID_LO]),
      .reload  (reload),
      .rdata   (id_rdata),
      .rej_q   (id_rej_q)
   );

   logic unused_id_low;
   assign unused_id_low = ^id_wdata[ID_LO-1:0];

   assign mode        = cur_mode;
   assign cap_present = (cur_mode != MODE_OFF);
   assign fault       = base_rej_q | id_rej_q;

   p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(base_wr || id_wr));

   p_cap_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rdata != 32'hFFFF_FFFF) |-> cap_present);

endmodule

// File: tb/sim_ctl_base_mode.sv
`timescale 1ns/1ps
module sim_ctl_base_mode;

   localparam int PA = 40;
   localparam logic [63:0] DEF = 64'h0000_0000_FEE0_0000;
   localparam logic [63:0] RESV = 64'hFF | (64'h1 << 9) | (~64'h0 << PA);
   localparam logic [63:0] EN  = 64'h800;
   localparam logic [63:0] EXT = 64'h400;
   localparam logic [63:0] BSP = 64'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bsp_strap = 1'b1;
   logic [7:0] init_id = 8'h3C;
   logic base_wr = 1'b0;
   logic [63:0] base_wdata = '0;
   logic id_wr = 1'b0;
   logic [31:0] id_wdata = '0;
   logic [63:0] base_rdata;
   logic [1:0] mode;
   logic [PA-1:0] decode_base;
   logic cap_present;
   logic [31:0] id_rdata;
   logic fault;
   logic regs_reset;

   always #2 clk = ~clk;

   ctl_base_mode u0 (
      .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap), .init_id(init_id),
      .base_wr(base_wr), .base_wdata(base_wdata), .id_wr(id_wr), .id_wdata(id_wdata),
      .base_rdata(base_rdata), .mode(mode), .decode_base(decode_base),
      .cap_present(cap_present), .id_rdata(id_rdata), .fault(fault),
      .regs_reset(regs_reset)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic m_en, m_ext, m_bsp, m_fault, m_rr;
   logic [63:0] m_base;
   logic [7:0] m_id;

   function automatic int m_mode();
      if (!m_en) return 0;
      if (m_ext) return 2;
      return 1;
   endfunction

   task automatic model_step();
      int cm, nm;
      logic nf, nrr, bad;
      if (!rst_n) begin
         m_en = 1; m_ext = 0; m_bsp = bsp_strap; m_base = DEF;
         m_id = init_id; m_fault = 0; m_rr = 0;
      end else begin
         nf = 0; nrr = 0;
         cm = m_mode();
         if (id_wr) begin
            if (cm == 1) m_id = id_wdata[31:24];
            else if (cm == 2) nf = 1;
         end
         if (base_wr) begin
            if (base_wdata[11] && base_wdata[10]) nm = 2;
            else if (base_wdata[11]) nm = 1;
            else if (base_wdata[10]) nm = 3;
            else nm = 0;
            bad = ((base_wdata & RESV) != 0) || nm == 3 ||
                  (cm == 0 && nm == 2) || (cm == 2 && nm == 1);
            if (bad) nf = 1;
            else begin
               if (cm != 0 && nm == 0) begin nrr = 1; m_id = init_id; end
               m_en = base_wdata[11]; m_ext = base_wdata[10]; m_bsp = base_wdata[8];
               m_base = base_wdata & ~64'hFFF;
            end
         end
         m_fault = nf; m_rr = nrr;
      end
   endtask

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic tick(string tag);
      logic [63:0] e_word;
      logic [31:0] e_id;
      int cm;
      @(posedge clk);
      model_step();
      #1;
      cm = m_mode();
      e_word = m_base | (m_en ? EN : 0) | (m_ext ? EXT : 0) | (m_bsp ? BSP : 0);
      e_id = (cm == 0) ? 32'hFFFF_FFFF : (cm == 1) ? {m_id, 24'h0} : {24'h0, m_id};
      chk(tag, "base_rdata", base_rdata, e_word);
      chk(tag, "mode", 64'(mode), 64'(cm));
      chk(tag, "decode_base", 64'(decode_base), m_base);
      chk(tag, "cap_present", 64'(cap_present), 64'(m_en));
      chk(tag, "id_rdata", 64'(id_rdata), 64'(e_id));
      chk(tag, "fault", 64'(fault), 64'(m_fault));
      chk(tag, "regs_reset", 64'(regs_reset), 64'(m_rr));
   endtask

   task automatic wbase(logic [63:0] d, string tag);
      base_wr = 1; base_wdata = d;
      tick(tag);
      base_wr = 0;
      tick(tag);
   endtask

   task automatic wid(logic [31:0] d, string tag);
      id_wr = 1; id_wdata = d;
      tick(tag);
      id_wr = 0;
      tick(tag);
   endtask

   localparam logic [63:0] RELOC = 64'h0000_0000_FED4_0000;

   initial begin
      tick("R1"); tick("R1");
      rst_n = 1;
      tick("R1"); tick("R1");
      wid(32'hA512_3456, "R8");
      wbase(RELOC | EN | BSP, "R5");
      wbase(RELOC | EN | 64'h1, "R4");
      wbase(RELOC | EN | 64'h200, "R4");
      wbase(RELOC | EN | (64'h1 << PA), "R4");
      wbase(RELOC | EN | (64'h1 << 63), "R4");
      wbase(RELOC | EXT, "R2");
      wbase(RELOC | EN | EXT | BSP, "R3");
      wid(32'h7700_0000, "R9");
      wbase(RELOC | EN | BSP, "R3");
      base_wr = 1; base_wdata = RELOC | EN;
      tick("R6"); tick("R6");
      base_wr = 0;
      tick("R6");
      wbase(DEF | EN | EXT, "R3");
      wbase(DEF, "R10");
      tick("R7");
      wid(32'h9900_0000, "R11");
      wbase(DEF | EXT, "R2");
      wbase(DEF | EN | EXT, "R3");
      wbase(DEF | EN | BSP, "R3");
      tick("R11");
      wid(32'h4200_0000, "R8");
      wbase(DEF, "R10");
      wbase(DEF | EN, "R3");
      wbase(DEF | EN | EXT, "R3");
      tick("R9");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule